// File: doc/BRIEF.md
# Display Frame Fetch Engine with Pixel FIFO

This block is a read-only bus master that keeps a pixel FIFO topped up from a frame buffer in memory. No processor is involved. It watches the FIFO fill level. Whenever the free space can take a whole burst, it asks the memory bus for a locked burst of 4, 8 or 16 consecutive words. Every returned word is written into the FIFO, and the read address moves forward by one word per beat. After the last word of the frame, the address returns to the frame base.

A downstream pixel processor drains the FIFO through a show-ahead pop port: the head word is always visible while the FIFO is not empty. Configuration inputs set the frame base word address, the frame length in words, the burst-length code and a run enable.

Clearing the enable lets any burst already requested run to its last beat. The engine then stops requesting, empties the FIFO and rewinds to the frame base. A pop on an empty FIFO sets a sticky underflow flag, which stays set until a clear pulse.

Top module: `disp_fetch_dma`

## Requirements
- R1: After reset, `mem_req`, `mem_lock` and `underflow` are 0 and `pix_empty` is 1.
- R2: The burst code `cfg_burst_sel` selects the burst length: 0 gives 4 words, 1 gives 8, 2 gives 16 and 3 also gives 16. After a grant, exactly that many `mem_rvalid` beats are written into the FIFO, and the burst then ends.
- R3: `mem_req` rises only when the FIFO free space (64 minus the fill level) is at least the burst length, so a granted burst never overflows the FIFO.
- R4: `mem_lock` is high from the first cycle of `mem_req` until the cycle after the last beat of the burst, and is low otherwise.
- R5: `mem_addr` equals `cfg_base` plus a word offset. The offset advances by one on each accepted beat and returns to 0 after offset `cfg_frame_words-1`.
- R6: The FIFO is first-in first-out. `pix_data` shows the oldest word whenever `pix_empty` is 0, and `pix_pop` removes it at the next clock edge.
- R7: With `cfg_enable` low, a burst already requested completes. No new request is raised, and once the engine is idle the FIFO is flushed (`pix_empty` becomes 1) and the offset returns to 0.
- R8: `pix_pop` while `pix_empty` is 1 sets `underflow` at the next edge. It stays set until `underflow_clr`, and a simultaneous set wins over the clear.
- R9: The burst length is captured when the request is raised. Changing `cfg_burst_sel` during a request or burst does not change that burst's beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Run enable |
| cfg_base | input | AW | Frame base word address |
| cfg_frame_words | input | FW | Frame length in words |
| cfg_burst_sel | input | 2 | Burst length code |
| underflow_clr | input | 1 | Clears the underflow flag |
| mem_req | output | 1 | Burst request to the memory bus |
| mem_lock | output | 1 | Bus lock, held for the whole burst |
| mem_addr | output | AW | Current beat word address |
| mem_gnt | input | 1 | Grant for the pending request |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | DW | Read data |
| pix_pop | input | 1 | Pop request from the pixel consumer |
| pix_data | output | DW | Head word of the FIFO |
| pix_empty | output | 1 | FIFO empty |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The embedded properties check the following on every cycle:
- no write into a full FIFO;
- no request without room for the captured burst length;
- the lock held across each burst;
- the beat count bounded and the captured length stable while the lock is held;
- the offset wrapping to the base;
- the flush emptying the FIFO;
- the underflow flag staying set.

Only the bench scenarios can show the rest: the exact sequence of data and addresses across frame wraps, the beat count per grant for every burst code, and the drain-then-flush order after a mid-burst disable. The bench uses random grant latency, random data gaps and random consumers, compared against a bench model of the frame contents.

// File: rtl/dfd_pkg.sv
`timescale 1ns/1ps
package dfd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_REQ   = 2'd1,
      ST_BURST = 2'd2
   } dfd_state_e;

   localparam int BLEN_W = 5;

   function automatic logic [BLEN_W-1:0] burst_words(input logic [1:0] sel);
      logic [BLEN_W-1:0] n;
      case (sel)
         2'd0:    n = 5'd4;
         2'd1:    n = 5'd8;
         default: n = 5'd16;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/dfd_fifo.sv
`timescale 1ns/1ps
module dfd_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 64,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_req,
   output logic [DW-1:0] rd_data,
   output logic          empty,
   output logic [LW-1:0] level,
   input  logic          uflow_clr,
   output logic          uflow
);

   localparam bit IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [DW-1:0] store [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          full, do_wr, do_rd;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_wr   = wr_en && !full && !flush;
   assign do_rd   = rd_req && !empty && !flush;
   assign rd_data = store[rd_ptr];

   generate
      if (IS_POW2) begin : g_ptr_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_ptr_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) store[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_nxt;
         if (do_rd) rd_ptr <= rd_nxt;
         case ({do_wr, do_rd})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                uflow <= 1'b0;
      else if (rd_req && empty)  uflow <= 1'b1;
      else if (uflow_clr)        uflow <= 1'b0;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && full)); // R3
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH)); // R6
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R7
   AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && !uflow_clr) |=> uflow); // R8

endmodule

// File: rtl/dfd_addr_gen.sv
`timescale 1ns/1ps
module dfd_addr_gen #(
   parameter int AW = 32,
   parameter int FW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          step,
   input  logic [AW-1:0] base,
   input  logic [FW-1:0] frame_words,
   output logic [AW-1:0] addr
);

   logic [FW-1:0] offset;
   logic          at_end;

   assign at_end = (frame_words <= FW'(1)) || (offset >= frame_words - FW'(1));

   generate
      if (FW >= AW) begin : g_off_trunc
         assign addr = base + offset[AW-1:0];
      end else begin : g_off_ext
         assign addr = base + {{(AW-FW){1'b0}}, offset};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || restart) offset <= '0;
      else if (step)         offset <= at_end ? '0 : offset + 1'b1;
   end

   AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart && $stable(base) && frame_words > FW'(1) &&
       addr == base + AW'(frame_words) - AW'(1)) |=> (addr == $past(base))); // R5
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart && $stable(base) && !at_end) |=> (addr == $past(addr) + AW'(1))); // R5

endmodule

// File: rtl/dfd_burst_ctrl.sv
`timescale 1ns/1ps
module dfd_burst_ctrl
   import dfd_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [1:0]    burst_sel,
   input  logic [LW-1:0] level,
   input  logic          mem_gnt,
   input  logic          mem_rvalid,
   output logic          mem_req,
   output logic          mem_lock,
   output logic          beat_accept,
   output logic          flush
);

   dfd_state_e        state;
   logic [BLEN_W-1:0] blen_q, beat_cnt, want;
   logic [LW:0]       free;
   logic              room, last_beat;

   assign want      = burst_words(burst_sel);
   assign free      = (LW+1)'(DEPTH) - {1'b0, level};
   assign room      = free >= (LW+1)'(want);
   assign last_beat = (beat_cnt == blen_q - 1'b1);

   assign mem_req     = (state == ST_REQ);
   assign mem_lock    = (state != ST_IDLE);
   assign beat_accept = (state == ST_BURST) && mem_rvalid;
   assign flush       = (state == ST_IDLE) && !enable;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         blen_q   <= 5'd4;
         beat_cnt <= '0;
      end else begin
         case (state)
            ST_IDLE: if (enable && room) begin
               state  <= ST_REQ;
               blen_q <= want;
            end
            ST_REQ: if (mem_gnt) begin
               state    <= ST_BURST;
               beat_cnt <= '0;
            end
            ST_BURST: if (mem_rvalid) begin
               beat_cnt <= beat_cnt + 1'b1;
               if (last_beat) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_REQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((LW+1)'(DEPTH) - {1'b0, level}) >= (LW+1)'(blen_q)); // R3
   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lock && !(beat_accept && last_beat)) |=> mem_lock); // R4
   AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_accept && last_beat) |=> !mem_lock); // R4
   AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BURST) |-> (beat_cnt < blen_q)); // R2
   AST_BLEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lock && $past(mem_lock)) |-> $stable(blen_q)); // R9
   AST_NO_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(enable)); // R7

endmodule

// File: rtl/disp_fetch_dma.sv
`timescale 1ns/1ps
module disp_fetch_dma #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int FW    = 20,
   parameter int DEPTH = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_enable,
   input  logic [AW-1:0] cfg_base,
   input  logic [FW-1:0] cfg_frame_words,
   input  logic [1:0]    cfg_burst_sel,
   input  logic          underflow_clr,
   output logic          mem_req,
   output logic          mem_lock,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_gnt,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata,
   input  logic          pix_pop,
   output logic [DW-1:0] pix_data,
   output logic          pix_empty,
   output logic          underflow
);

   localparam int LW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 16) begin : g_bad_depth
         $error("DEPTH must hold at least one 16-word burst");
      end
      if (AW < 2 || DW < 1 || FW < 2) begin : g_bad_width
         $error("AW, DW and FW are too small");
      end
   endgenerate

   logic [LW-1:0] level;
   logic          beat_accept, flush;

   dfd_burst_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (cfg_enable),
      .burst_sel   (cfg_burst_sel),
      .level       (level),
      .mem_gnt     (mem_gnt),
      .mem_rvalid  (mem_rvalid),
      .mem_req     (mem_req),
      .mem_lock    (mem_lock),
      .beat_accept (beat_accept),
      .flush       (flush)
   );

   dfd_addr_gen #(.AW(AW), .FW(FW)) u_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (flush),
      .step        (beat_accept),
      .base        (cfg_base),
      .frame_words (cfg_frame_words),
      .addr        (mem_addr)
   );

   dfd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .wr_en     (beat_accept),
      .wr_data   (mem_rdata),
      .rd_req    (pix_pop),
      .rd_data   (pix_data),
      .empty     (pix_empty),
      .level     (level),
      .uflow_clr (underflow_clr),
      .uflow     (underflow)
   );

endmodule

// File: tb/sim_disp_fetch_dma.sv
`timescale 1ns/1ps
module sim_disp_fetch_dma;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0;
   logic [31:0] cfg_base = 32'h1000;
   logic [19:0] cfg_frame_words = 20'd40;
   logic [1:0]  cfg_burst_sel = 2'd0;
   logic        underflow_clr = 1'b0;
   logic        mem_req, mem_lock;
   logic [31:0] mem_addr;
   logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        pix_pop = 1'b0;
   logic [31:0] pix_data;
   logic        pix_empty, underflow;

   always #2.5 clk = ~clk;

   disp_fetch_dma u0 (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
      .cfg_frame_words(cfg_frame_words), .cfg_burst_sel(cfg_burst_sel),
      .underflow_clr(underflow_clr), .mem_req(mem_req), .mem_lock(mem_lock),
      .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .pix_pop(pix_pop), .pix_data(pix_data),
      .pix_empty(pix_empty), .underflow(underflow)
   );

   int total = 0, bad = 0, cyc = 0;
   bit done = 0;
   int level_m = 0, pidx = 0, woff = 0, beats_left = 0, blen_m = 4, gdly = 0, mst = 0;
   bit uf_m = 0;

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
   endfunction

   function automatic int blen_of(input logic [1:0] s);
      return (s == 2'd0) ? 4 : (s == 2'd1) ? 8 : 16;
   endfunction

   function automatic logic [31:0] waddr(input int off);
      return cfg_base + 32'(off % int'(cfg_frame_words));
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 150000 && !done) begin
         bad++; total++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // One bench cycle: observe outputs at the negedge, then drive the next inputs.
   task automatic step(input int pop_pct, input int rv_pct, input int sel_pct, input int clr_pct);
      bit pop, clr;
      @(negedge clk);
      chk(underflow == uf_m, "R8 underflow", underflow, uf_m);
      if (cfg_enable) chk(pix_empty == (level_m == 0), "R6 empty", pix_empty, level_m == 0);
      mem_gnt = 1'b0; mem_rvalid = 1'b0;
      if (mst == 3) begin
         chk(mem_lock == 1'b0, "R4 lock drop after last beat", mem_lock, 0);
         mst = 0;
      end
      if (mst == 0) begin
         if (mem_req) begin
            chk(cfg_enable == 1'b1, "R7 no request while disabled", cfg_enable, 1);
            blen_m = blen_of(cfg_burst_sel);
            chk(level_m <= 64 - blen_m, "R3 room for burst", level_m, 64 - blen_m);
            chk(mem_lock == 1'b1, "R4 lock with request", mem_lock, 1);
            gdly = $urandom_range(0, 3);
            mst = 1;
         end else begin
            chk(mem_lock == 1'b0, "R4 lock idle", mem_lock, 0);
         end
      end
      if (mst == 1) begin
         chk(mem_req && mem_lock, "R4 request held", {mem_req, mem_lock}, 2'b11);
         if (gdly == 0) begin
            chk(mem_addr == waddr(woff), "R5 burst start address", mem_addr, waddr(woff));
            mem_gnt = 1'b1;
            beats_left = blen_m;
            mst = 2;
         end else gdly--;
      end else if (mst == 2) begin
         chk(mem_lock == 1'b1 && mem_req == 1'b0, "R2 R9 burst beats remain", {mem_req, mem_lock}, 2'b01);
         if ($urandom_range(0, 99) < rv_pct) begin
            chk(mem_addr == waddr(woff), "R5 beat address", mem_addr, waddr(woff));
            mem_rvalid = 1'b1;
            mem_rdata = pat(waddr(woff));
            woff = (woff + 1) % int'(cfg_frame_words);
            level_m++;
            beats_left--;
            if (beats_left == 0) mst = 3;
         end
      end
      if ($urandom_range(0, 99) < sel_pct) cfg_burst_sel = 2'($urandom_range(0, 3)); // R9 changes mid-burst
      pop = cfg_enable && ($urandom_range(0, 99) < pop_pct);
      clr = ($urandom_range(0, 99) < clr_pct);
      pix_pop = pop;
      underflow_clr = clr;
      if (pop && !pix_empty) begin
         chk(pix_data == pat(waddr(pidx)), "R6 pixel order", pix_data, pat(waddr(pidx)));
         pidx++;
         level_m--;
      end
      uf_m = (pop && pix_empty) || (uf_m && !clr);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (4) @(negedge clk);
      chk(mem_req == 0 && mem_lock == 0, "R1 reset bus", {mem_req, mem_lock}, 0);
      chk(pix_empty == 1, "R1 reset empty", pix_empty, 1);
      chk(underflow == 0, "R1 reset underflow", underflow, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_req == 0, "R1 no request before enable", mem_req, 0);

      // balanced random traffic, 40-word frame
      cfg_enable = 1'b1;
      repeat (6000) step(50, 70, 5, 2);
      // slow consumer: FIFO stays nearly full
      repeat (3000) step(8, 90, 5, 0);
      // fast consumer with empties and underflow
      repeat (3000) step(95, 30, 5, 3);

      // R7: disable in the middle of a burst
      while (mst != 2) step(0, 70, 0, 0);
      step(0, 0, 0, 0);
      cfg_enable = 1'b0;
      while (mst != 0) step(0, 70, 0, 0);
      repeat (3) step(0, 0, 0, 0);
      chk(pix_empty == 1, "R7 flushed after disable", pix_empty, 1);
      chk(mem_req == 0, "R7 idle after disable", mem_req, 0);
      level_m = 0; pidx = 0; woff = 0;

      // R8: directed underflow, sticky, set over clear
      @(negedge clk);
      pix_pop = 1'b1; underflow_clr = 1'b0;
      @(negedge clk);
      pix_pop = 1'b0;
      chk(underflow == 1, "R8 set on empty pop", underflow, 1);
      chk(pix_empty == 1, "R8 empty pop has no effect", pix_empty, 1);
      repeat (5) @(negedge clk);
      chk(underflow == 1, "R8 sticky", underflow, 1);
      underflow_clr = 1'b1;
      @(negedge clk);
      underflow_clr = 1'b0;
      chk(underflow == 0, "R8 cleared", underflow, 0);
      pix_pop = 1'b1; underflow_clr = 1'b1;
      @(negedge clk);
      pix_pop = 1'b0; underflow_clr = 1'b0;
      chk(underflow == 1, "R8 set wins over clear", underflow, 1);
      underflow_clr = 1'b1;
      @(negedge clk);
      underflow_clr = 1'b0;
      uf_m = 0;

      // new frame: 24 words, bursts of 16 cross the wrap
      cfg_base = 32'h0002_FFF0;
      cfg_frame_words = 20'd24;
      cfg_burst_sel = 2'd2;
      @(negedge clk);
      cfg_enable = 1'b1;
      repeat (3000) step(60, 80, 0, 0);
      cfg_burst_sel = 2'd3;
      repeat (2000) step(60, 80, 0, 0);
      cfg_burst_sel = 2'd1;
      repeat (2000) step(40, 60, 2, 1);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule